// File: doc/BRIEF.md
# Masked Vector Multiply-Add Lanes

This unit applies an integer multiply-add to every element of a short vector in one step. Each element has three operands: an addend and two factors. The product of the two factors is cut to the element width, the addend is added to it, and the sum wraps at the element width. An 8-bit control word decides, element by element, whether that sum is kept. An element that is not kept takes a fallback value. The top bit of the same control word picks the fallback: zero, or the element's own addend.

The old contents of the destination never reach the unit. Its data inputs are the three source vectors and the control word, and nothing else. Because the fallback is the addend, a masked operation depends only on operands it already reads. No extra dependency on a previous result is created.

Operands enter through a valid/ready input handshake and results leave through a valid/ready output handshake. There is one register stage between them. An input is accepted on a rising edge when `in_valid` and `in_ready` are both high. While a result is held and `out_ready` is low, the unit refuses new input, and the result and `out_valid` stay frozen. When the held result drains on the same edge that a new input arrives, the new result replaces it with no bubble.

Top module: `vmadd_lanes`

## Requirements
- R1: For an element whose enable bit is 1, the result is (addend + ((factor_a × factor_b) mod 2^16)) mod 2^16.
- R2: When `mask_ctl[7]` is 0 (merge mode), an element whose enable bit is 0 returns that element's addend unchanged.
- R3: When `mask_ctl[7]` is 1 (zero mode), an element whose enable bit is 0 returns 0.
- R4: Element i (bits 16i+15:16i of every vector) is enabled by `mask_ctl[i]` for i = 0..3. Bits `mask_ctl[6:4]` have no effect on the result.
- R5: With `mask_ctl[3:0]` = 4'b1111, every element equals the full multiply-add in both modes.
- R6: An accepted input produces its result on `result`, with `out_valid` high, right after the rising edge that accepted it. `out_valid` falls after an edge on which the result drained and no new input was accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result` stays unchanged.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high, so that a drain and a new acceptance can happen on the same edge.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and control word are present |
| in_ready | output | 1 | Unit can accept operands on this edge |
| src_add | input | 64 | Addend vector, 4 × 16 bits, element 0 in the low bits |
| src_fa | input | 64 | First factor vector |
| src_fb | input | 64 | Second factor vector |
| mask_ctl | input | 8 | Bits [3:0] are the element enables; bit 7 selects the mode (1 = zero, 0 = merge) |
| out_valid | output | 1 | `result` holds a valid vector |
| out_ready | input | 1 | Consumer takes the result on this edge |
| result | output | 64 | Result vector |

## Verification
Two things can happen on the same edge: the held result drains to the consumer, and a new operand set enters the stage. The bench drives `out_ready` and `in_valid` at random, so back-to-back handshakes, stalls and idle gaps all occur. Each result is popped from a queue-based model only on the edge where it drains, and compared element by element. Running both modes with random, empty, full, single-bit and noisy-high-bit masks shows whether a replacement on a drain edge is lost, duplicated, or built with the wrong fallback.

// File: rtl/vmadd_pkg.sv
package vmadd_pkg;
  typedef enum logic {
    FB_MERGE = 1'b0,
    FB_ZERO  = 1'b1
  } fallback_e;
endpackage

// File: rtl/vmadd_mask_decode.sv
module vmadd_mask_decode
  import vmadd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int MASK_W = 8
) (
  input  logic [MASK_W-1:0] mask_ctl,
  output logic [LANES-1:0]  lane_en,
  output fallback_e         fb_mode
);
  localparam int MODE_BIT = MASK_W - 1;

  always_comb begin
    lane_en = mask_ctl[LANES-1:0];
    fb_mode = fallback_e'(mask_ctl[MODE_BIT]);
  end
endmodule

// File: rtl/vmadd_lane.sv
module vmadd_lane
  import vmadd_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  logic [ELEM_W-1:0] add_op,
  input  logic [ELEM_W-1:0] fa_op,
  input  logic [ELEM_W-1:0] fb_op,
  input  logic              enable,
  input  fallback_e         fb_mode,
  output logic [ELEM_W-1:0] lane_out
);
  logic [ELEM_W-1:0] prod_trunc;
  logic [ELEM_W-1:0] fused;
  logic [ELEM_W-1:0] fallback;

  always_comb begin
    prod_trunc = fa_op * fb_op;
    fused      = add_op + prod_trunc;
    fallback   = (fb_mode == FB_ZERO) ? '0 : add_op;
    lane_out   = enable ? fused : fallback;
  end
endmodule

// File: rtl/vmadd_out_stage.sv
module vmadd_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              held;
  logic [DATA_W-1:0] store;

  assign up_ready = !held || dn_ready;
  assign dn_valid = held;
  assign dn_data  = store;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      store <= '0;
    end else if (up_valid && up_ready) begin
      held  <= 1'b1;
      store <= up_data;
    end else if (dn_ready) begin
      held  <= 1'b0;
    end
  end
endmodule

// File: rtl/vmadd_lanes.sv
module vmadd_lanes
  import vmadd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ELEM_W = 16,
  parameter int MASK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ELEM_W-1:0] src_add,
  input  logic [LANES*ELEM_W-1:0] src_fa,
  input  logic [LANES*ELEM_W-1:0] src_fb,
  input  logic [MASK_W-1:0]       mask_ctl,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*ELEM_W-1:0] result
);
  localparam int VEC_W = LANES * ELEM_W;

  logic [LANES-1:0] lane_en;
  fallback_e        fb_mode;
  logic [VEC_W-1:0] comb_vec;

  vmadd_mask_decode #(
    .LANES (LANES),
    .MASK_W(MASK_W)
  ) u_decode (
    .mask_ctl(mask_ctl),
    .lane_en (lane_en),
    .fb_mode (fb_mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vmadd_lane #(
      .ELEM_W(ELEM_W)
    ) u_lane (
      .add_op  (src_add[g*ELEM_W +: ELEM_W]),
      .fa_op   (src_fa[g*ELEM_W +: ELEM_W]),
      .fb_op   (src_fb[g*ELEM_W +: ELEM_W]),
      .enable  (lane_en[g]),
      .fb_mode (fb_mode),
      .lane_out(comb_vec[g*ELEM_W +: ELEM_W])
    );
  end

  vmadd_out_stage #(
    .DATA_W(VEC_W)
  ) u_stage (
    .clk     (clk),
    .rst     (rst),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (comb_vec),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (result)
  );
endmodule

// File: rtl/vmadd_lanes_chk.sv
module vmadd_lanes_chk #(
  parameter int LANES  = 4,
  parameter int ELEM_W = 16,
  parameter int MASK_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LANES*ELEM_W-1:0] src_add,
  input logic [MASK_W-1:0]       mask_ctl,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*ELEM_W-1:0] result
);
  localparam int MODE_BIT = MASK_W - 1;

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r6_accept_shows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r6_drain_empties: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_empty_accepts: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r3_all_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mask_ctl[MODE_BIT] && mask_ctl[LANES-1:0] == '0)
      |=> result == '0);

  a_r2_all_merge: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !mask_ctl[MODE_BIT] && mask_ctl[LANES-1:0] == '0)
      |=> result == $past(src_add));
endmodule

bind vmadd_lanes vmadd_lanes_chk #(
  .LANES (LANES),
  .ELEM_W(ELEM_W),
  .MASK_W(MASK_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .src_add  (src_add),
  .mask_ctl (mask_ctl),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .result   (result)
);

// File: tb/test_vmadd_lanes.sv
module test_vmadd_lanes;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] src_add = '0;
  logic [63:0] src_fa = '0;
  logic [63:0] src_fb = '0;
  logic [7:0]  mask_ctl = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [63:0] val;
    logic [7:0]  mask;
  } exp_t;
  exp_t exp_q[$];

  bit          fresh_reset = 1'b0;
  bit          prev_stall  = 1'b0;
  logic [63:0] prev_result = '0;

  always #2.5 clk = ~clk;

  vmadd_lanes i_vmadd_lanes (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_add(src_add), .src_fa(src_fa), .src_fb(src_fb), .mask_ctl(mask_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] x,
                                        logic [63:0] y, logic [7:0] m);
    logic [63:0] r;
    for (int e = 0; e < 4; e++) begin
      int unsigned av = a[e*16 +: 16];
      int unsigned pv = (int'(x[e*16 +: 16]) * int'(y[e*16 +: 16])) % 65536;
      if (m[e])      r[e*16 +: 16] = 16'((av + pv) % 65536);
      else if (m[7]) r[e*16 +: 16] = 16'h0000;
      else           r[e*16 +: 16] = 16'(av);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference comparison away from the active edge, then model step.
  always @(negedge clk) begin
    if (!done) begin
      bit exp_v;
      exp_v = (exp_q.size() != 0);
      check(out_valid == exp_v, "R6", 64'(out_valid), 64'(exp_v));
      check(in_ready == (!exp_v || out_ready), "R8", 64'(in_ready),
            64'(!exp_v || out_ready));
      if (fresh_reset)
        check(!out_valid && result == '0, "R9", result, 64'h0);
      if (prev_stall)
        check(result == prev_result, "R7", result, prev_result);
      if (exp_v) begin
        for (int e = 0; e < 4; e++) begin
          string tag;
          logic [7:0] m;
          m = exp_q[0].mask;
          if (m[3:0] == 4'hF)     tag = "R5";
          else if (m[6:4] != 0)   tag = "R4";
          else if (m[e])          tag = "R1";
          else if (m[7])          tag = "R3";
          else                    tag = "R2";
          check(result[e*16 +: 16] == exp_q[0].val[e*16 +: 16], tag,
                64'(result[e*16 +: 16]), 64'(exp_q[0].val[e*16 +: 16]));
        end
      end
      prev_stall  = exp_v && !out_ready && !rst;
      prev_result = result;
      if (rst) begin
        exp_q.delete();
        fresh_reset = 1'b1;
      end else begin
        bit acc;
        acc = (exp_q.size() == 0) || out_ready;
        if (exp_v && out_ready) void'(exp_q.pop_front());
        if (in_valid && acc) begin
          exp_t n;
          n.val  = model(src_add, src_fa, src_fb, mask_ctl);
          n.mask = mask_ctl;
          exp_q.push_back(n);
          fresh_reset = 1'b0;
        end
      end
    end
  end

  task automatic send(logic [7:0] m, int ready_pct);
    @(posedge clk); #1;
    in_valid = 1'b1;
    src_add  = {$urandom, $urandom};
    src_fa   = {$urandom, $urandom};
    src_fb   = {$urandom, $urandom};
    mask_ctl = m;
    out_ready = ($urandom_range(99) < ready_pct);
    while (!in_ready) begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(99) < ready_pct);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid  = ($urandom_range(3) == 0);
      src_add   = {$urandom, $urandom};
      mask_ctl  = 8'($urandom);
      out_ready = 1'b1;
      in_valid  = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R9: reset state observed before any traffic
    idle(2);
    // R2, R3: empty masks in both modes
    for (int k = 0; k < 20; k++) send({1'b0, 3'b000, 4'h0}, 100);
    for (int k = 0; k < 20; k++) send({1'b1, 3'b000, 4'h0}, 100);
    // R5: full masks in both modes
    for (int k = 0; k < 20; k++) send({k[0], 3'b000, 4'hF}, 100);
    // R4: single-lane enables with noisy bits 6:4
    for (int k = 0; k < 32; k++)
      send({k[0], 3'(k), 4'(1 << (k % 4))}, 100);
    // R1, R6, R7, R8: random masks under back-pressure
    for (int k = 0; k < 1500; k++) send(8'($urandom), 60);
    idle(3);
    // R9: reset in the middle of traffic
    send(8'h8F, 0);
    @(posedge clk); #1 rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    idle(2);
    for (int k = 0; k < 500; k++) send(8'($urandom), 30);
    idle(5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule